// File: doc/BRIEF.md
# Interrupt Qualifier and Dispatcher

This block sits between a set of peripheral modules and the CPU's interrupt entry. Each module has one asynchronous request line and one synchronous request line. Asynchronous lines are synchronized and then pulse-width filtered on the undivided clock `clk`. Synchronous lines are sampled on system clock ticks. Both kinds of request from one module fold into a single sticky pending bit. An internal prescaler makes the system clock tick (`sys_tick`) from `clk` at a ratio chosen by `div_sel`. All pending and dispatch state advances only on those ticks.

Every module has the same hardware priority, and all of them share one vector. A small state machine decides when to raise `vec_req`. It needs a pending bit with its mask bit set, the global enable, and a cleared in-service flag. While it is in ST_RUN, a tick with an eligible request moves it to ST_VECTOR. A tick with a prefix write moves it to ST_GUARD instead, which is the one-tick exception window. ST_GUARD moves to ST_VECTOR if a request is eligible, stays in ST_GUARD on another prefix write, and otherwise returns to ST_RUN. ST_VECTOR drives `vec_req` and `ins` for one system period and always moves on to ST_SERVICE. ST_SERVICE holds `ins` until a tick with `ins_clr` returns it to ST_RUN. Software reads `pend` to choose which module to serve first.

Top module: `irq_qualify_top`

## Requirements
- R1: While reset is held and right after it is released, `vec_req`, `ins` and `pend` are all zero.
- R2: An asynchronous request held high for fewer than 3 consecutive `clk` edges never sets its `pend` bit.
- R3: An asynchronous request held high for 3 or more `clk` edges sets its `pend` bit on the first tick after the filter qualifies it. With `div_sel`=0 the bit becomes visible after the 6th `clk` edge counted from the first edge that samples the request high, and not before. With larger ratios it is never visible before that 6th edge.
- R4: `sys_tick` pulses once every 1, 2, 4 or 8 `clk` cycles for `div_sel` values 0, 1, 2 and 3.
- R5: A `sync_req` bit that is high at a tick sets the matching `pend` bit. Bit i of `pend` belongs to module i. A module that raises both its synchronous and its asynchronous line gets exactly one `pend` bit.
- R6: `pend` bits hold their value between ticks and stay set until a tick with the matching `pend_clr` bit high. If a set and a clear arrive on the same tick, the set wins.
- R7: When `glob_en` is 1, `ins` is 0 and some `pend` bit has its `mask` bit at 1 at a tick, `vec_req` and `ins` both become 1 after the next tick edge, and `vec_req` lasts exactly one system period.
- R8: A module whose `mask` bit is 0 never causes `vec_req`. Nothing causes `vec_req` while `glob_en` is 0.
- R9: Once set, `ins` stays at 1 and blocks any further `vec_req` until a tick with `ins_clr` high. After that tick an eligible request vectors on the following tick.
- R10: A tick with `pfx_wr` high in ST_RUN makes the next tick a window in which no vector is issued. An eligible request is then vectored one tick later than it would be without the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_sel | input | 2 | System clock ratio select: 0=/1, 1=/2, 2=/4, 3=/8 |
| async_req | input | NUM_MOD | Raw asynchronous request, one per module |
| sync_req | input | NUM_MOD | Synchronous request, one per module, sampled on ticks |
| mask | input | NUM_MOD | Per-module enable, 1 lets the module vector |
| glob_en | input | 1 | Global interrupt enable |
| pfx_wr | input | 1 | Prefix register written this system cycle |
| ins_clr | input | 1 | Clears the in-service flag on a tick |
| pend_clr | input | NUM_MOD | Clears pending bits on a tick |
| sys_tick | output | 1 | System clock enable derived from `clk` |
| vec_req | output | 1 | Request to vector to the shared interrupt address |
| ins | output | 1 | In-service flag |
| pend | output | NUM_MOD | Pending status, one bit per module |

## Verification
The bench probes the filter edge with pulses of exactly two and three `clk` edges. A filter that is off by one either lets a glitch through or drops a valid request. It times the first visible `pend` edge to the cycle, which catches any extra or missing synchronizer stage. It fires a prefix write together with a newly eligible request, so a design without the window vectors one tick early. It also raises a set and a clear on the same tick, where a design with the wrong priority loses the request. Finally it keeps a pending request alive while `ins` is held, which catches a design that re-vectors without waiting for `ins_clr`.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int FILT_LEN = 3;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_GUARD,
        ST_VECTOR,
        ST_SERVICE
    } disp_state_t;
endpackage

// File: rtl/irq_prescale.sv
module irq_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim = '0;
        for (int i = 0; i < CNT_W; i++) begin
            lim[i] = (i < int'(div_sel));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    assign tick = ((cnt & lim) == lim);

    AST_TICK_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel == '0) |-> tick); // R4
endmodule

// File: rtl/irq_pulse_filter.sv
module irq_pulse_filter #(
    parameter int LEN = irq_pkg::FILT_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic consume,
    output logic hit
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic          s1, s2;
    logic [CW-1:0] run;
    logic          fire;

    assign fire = s2 && (run == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1  <= 1'b0;
            s2  <= 1'b0;
            run <= '0;
            hit <= 1'b0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (!s2)            run <= '0;
            else if (run != LAST) run <= run + 1'b1;
            hit <= fire | (hit & ~consume);
        end
    end

    AST_HIT_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> ($past(s2, 1) && $past(s2, 2))); // R2
endmodule

// File: rtl/irq_dispatch_fsm.sv
module irq_dispatch_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req_any,
    input  logic glob_en,
    input  logic pfx_wr,
    input  logic ins_clr,
    output logic vec_req,
    output logic ins
);
    disp_state_t st, st_nx;
    logic        elig;

    assign elig = glob_en && req_any;

    always_comb begin
        st_nx = st;
        if (tick) begin
            unique case (st)
                ST_RUN:     if (pfx_wr) st_nx = ST_GUARD;
                            else if (elig) st_nx = ST_VECTOR;
                ST_GUARD:   if (pfx_wr) st_nx = ST_GUARD;
                            else if (elig) st_nx = ST_VECTOR;
                            else st_nx = ST_RUN;
                ST_VECTOR:  st_nx = ST_SERVICE;
                ST_SERVICE: if (ins_clr) st_nx = ST_RUN;
                default:    st_nx = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= st_nx;
    end

    always_comb begin
        vec_req = (st == ST_VECTOR);
        ins     = (st == ST_VECTOR) || (st == ST_SERVICE);
    end

    AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pfx_wr && st == ST_RUN) |=> !vec_req); // R10
    AST_NO_REVECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st == ST_SERVICE && !ins_clr) |=> !vec_req); // R9
    AST_VEC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_req) |-> $past(glob_en && req_any)); // R8
    AST_VEC_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && vec_req) |=> !vec_req); // R7
endmodule

// File: rtl/irq_qualify_top.sv
module irq_qualify_top #(
    parameter int NUM_MOD = 4,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   div_sel,
    input  logic [NUM_MOD-1:0] async_req,
    input  logic [NUM_MOD-1:0] sync_req,
    input  logic [NUM_MOD-1:0] mask,
    input  logic               glob_en,
    input  logic               pfx_wr,
    input  logic               ins_clr,
    input  logic [NUM_MOD-1:0] pend_clr,
    output logic               sys_tick,
    output logic               vec_req,
    output logic               ins,
    output logic [NUM_MOD-1:0] pend
);
    logic [NUM_MOD-1:0] async_hit;
    logic [NUM_MOD-1:0] pend_q;

    irq_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .tick    (sys_tick)
    );

    for (genvar m = 0; m < NUM_MOD; m++) begin : g_filt
        irq_pulse_filter #(.LEN(irq_pkg::FILT_LEN)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw     (async_req[m]),
            .consume (sys_tick),
            .hit     (async_hit[m])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pend_q <= '0;
        else if (sys_tick) pend_q <= (pend_q & ~pend_clr) | sync_req | async_hit;
    end

    assign pend = pend_q;

    irq_dispatch_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sys_tick),
        .req_any (|(pend_q & mask)),
        .glob_en (glob_en),
        .pfx_wr  (pfx_wr),
        .ins_clr (ins_clr),
        .vec_req (vec_req),
        .ins     (ins)
    );

    AST_PEND_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_tick |=> $stable(pend_q)); // R6
    AST_PEND_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_tick && (sync_req != '0)) |=> ((pend_q & $past(sync_req)) == $past(sync_req))); // R5
endmodule

// File: tb/irq_qualify_top_bench.sv
module irq_qualify_top_bench;
    localparam int NM = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    div_sel = '0;
    logic [NM-1:0] async_req = '0, sync_req = '0, mask = '0, pend_clr = '0;
    logic          glob_en = 1'b0, pfx_wr = 1'b0, ins_clr = 1'b0;
    logic          sys_tick, vec_req, ins;
    logic [NM-1:0] pend;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    irq_qualify_top #(.NUM_MOD(NM), .SEL_W(2)) u_irq_qualify_top (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .async_req(async_req),
        .sync_req(sync_req), .mask(mask), .glob_en(glob_en), .pfx_wr(pfx_wr),
        .ins_clr(ins_clr), .pend_clr(pend_clr), .sys_tick(sys_tick),
        .vec_req(vec_req), .ins(ins), .pend(pend)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        pend_clr = '1;
        ins_clr  = 1'b1;
        step(1);
        pend_clr = '0;
        ins_clr  = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        step(2);
        check("R1 vec_req in reset", int'(vec_req), 0);
        check("R1 ins in reset", int'(ins), 0);
        rst_n = 1'b1;
        step(1);
        check("R1 pend after reset", int'(pend), 0);
        check("R1 ins after reset", int'(ins), 0);
    endtask

    task automatic t_tick_rate();
        for (int s = 0; s < 4; s++) begin
            int n = 0;
            div_sel = 2'(s);
            step(1);
            for (int i = 0; i < 32; i++) begin
                step(1);
                if (sys_tick) n++;
            end
            check($sformatf("R4 ticks in 32 cycles sel=%0d", s), n, 32 >> s);
        end
        div_sel = '0;
        step(1);
    endtask

    task automatic t_async_short();
        async_req[0] = 1'b1;
        step(2);
        async_req[0] = 1'b0;
        step(12);
        check("R2 two-edge pulse ignored", int'(pend[0]), 0);
    endtask

    task automatic t_async_exact();
        async_req[0] = 1'b1;
        step(3);
        async_req[0] = 1'b0;
        step(2);
        check("R3 pend not yet after 5 edges", int'(pend[0]), 0);
        step(1);
        check("R3 pend after 6th edge", int'(pend[0]), 1);
        clear_all();
        check("R6 pend cleared", int'(pend), 0);
    endtask

    task automatic t_async_div4();
        int seen = 0;
        div_sel = 2'd2;
        step(1);
        async_req[1] = 1'b1;
        step(3);
        async_req[1] = 1'b0;
        step(2);
        check("R3 div4 not before 6th edge", int'(pend[1]), 0);
        for (int i = 0; i < 8; i++) begin
            step(1);
            if (pend[1]) seen = 1;
        end
        check("R3 div4 recognized", seen, 1);
        async_req[2] = 1'b1;
        step(2);
        async_req[2] = 1'b0;
        step(16);
        check("R2 div4 short pulse ignored", int'(pend[2]), 0);
        div_sel = '0;
        step(1);
        clear_all();
    endtask

    task automatic t_merge();
        sync_req[1]  = 1'b1;
        async_req[1] = 1'b1;
        step(4);
        sync_req[1]  = 1'b0;
        async_req[1] = 1'b0;
        step(8);
        check("R5 one module one bit", int'(pend), 2);
        pend_clr[1] = 1'b1;
        sync_req[1] = 1'b1;
        step(1);
        pend_clr[1] = 1'b0;
        sync_req[1] = 1'b0;
        check("R6 set wins over clear", int'(pend[1]), 1);
        step(3);
        check("R6 pend sticky", int'(pend[1]), 1);
        clear_all();
    endtask

    task automatic t_vector_and_ins();
        mask = '1;
        glob_en = 1'b1;
        sync_req[2] = 1'b1;
        step(1);
        sync_req[2] = 1'b0;
        check("R5 sync sets pend", int'(pend[2]), 1);
        check("R7 no vec yet", int'(vec_req), 0);
        step(1);
        check("R7 vec_req raised", int'(vec_req), 1);
        check("R7 ins with vec", int'(ins), 1);
        step(1);
        check("R7 vec one period", int'(vec_req), 0);
        check("R9 ins held", int'(ins), 1);
        step(4);
        check("R9 no revector while ins", int'(vec_req), 0);
        ins_clr = 1'b1;
        step(1);
        ins_clr = 1'b0;
        check("R9 ins cleared", int'(ins), 0);
        step(1);
        check("R9 revector after clear", int'(vec_req), 1);
        step(1);
        clear_all();
        glob_en = 1'b0;
    endtask

    task automatic t_gating();
        mask = 4'b1011;
        glob_en = 1'b1;
        sync_req[2] = 1'b1;
        step(1);
        sync_req[2] = 1'b0;
        step(4);
        check("R8 masked module no vec", int'(vec_req) | int'(ins), 0);
        glob_en = 1'b0;
        mask = '1;
        step(4);
        check("R8 glob_en off no vec", int'(vec_req) | int'(ins), 0);
    endtask

    task automatic t_prefix();
        glob_en = 1'b1;
        pfx_wr  = 1'b1;
        step(1);
        pfx_wr  = 1'b0;
        check("R10 window blocks vec", int'(vec_req), 0);
        step(1);
        check("R10 vec one tick late", int'(vec_req), 1);
        step(1);
        glob_en = 1'b0;
        clear_all();
        check("R10 back to idle", int'(ins), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_tick_rate();
        t_async_short();
        t_async_exact();
        t_async_div4();
        t_merge();
        t_vector_and_ins();
        t_gating();
        t_prefix();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule